// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Window

This block is the software-visible register window of a two-channel bus-master DMA controller for a disk interface. It decodes a 16-byte I/O window. Each channel holds a command byte, a status byte and a 32-bit pointer to its descriptor table. Accesses are qualified by address and by access size. The command bits and the table pointer go out to a DMA engine. That engine returns per-channel error and interrupt pulses, and the block records them in the status byte.

The status byte combines four kinds of bit. Two bits hold software-defined capability flags. One bit is a read-only "channel active" flag that only the command start bit can move. Two bits are event flags that software clears by writing ones. The remaining three bits always read as zero. The command and status bytes only accept byte accesses. Wider reads there return all ones across the access width, and wider writes there have no effect. The table pointer accepts byte, half-word and word accesses on their byte lanes.

Top module: `dbm_regs`

## Requirements
- R1: Address bit 3 selects the channel (0 for channel 0, 1 for channel 1). Address bit 2 selects between the command/status dword (0) and the table pointer (1). Address bits 1:0 give the byte offset within that dword.
- R2: A byte write at offset 0 of the command/status dword stores bit 0 (start, driven on `dma_start_o`) and bit 3 (direction, driven on `dma_dir_o`). A byte read there returns those two bits in place, with every other bit zero.
- R3: Access size is encoded on `io_size` as 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit. A non-byte read of a command/status dword returns 0x0000FFFF for 16-bit and 0xFFFFFFFF for 32-bit. A non-byte write there changes no register.
- R4: A byte read at offset 1 or 3 of a command/status dword returns 0xFF.
- R5: A byte write at offset 2 loads status bits 6 and 5 from the written data. Status bits 7, 4 and 3 always read zero.
- R6: Status bit 0 (active) is never changed by a status write. Writing the start bit as 1 sets it, and writing the start bit as 0 clears it.
- R7: Status bits 2 (interrupt) and 1 (error) are write-one-to-clear. A written 0 leaves the bit unchanged.
- R8: A one-cycle pulse on `err_i[c]` sets status bit 1 of channel c, and a pulse on `irq_i[c]` sets bit 2. When a pulse and a clearing write land in the same cycle, the bit ends up set.
- R9: The table pointer takes writes only on the byte lanes selected by size and offset, and reads return the selected lanes right-aligned. Its bits 1:0 are always zero.
- R10: After reset, all command, status and pointer bits are zero, and `bar_low_o` reads 0x01 (I/O-space window).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Byte address within the window |
| io_size | input | 2 | Access size code |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 32 | Write data, lane 0 at bit 0 |
| io_rdata | output | 32 | Combinational read data for the current address and size |
| err_i | input | 2 | Per-channel error pulse from the engine |
| irq_i | input | 2 | Per-channel interrupt pulse from the engine |
| dma_start_o | output | 2 | Per-channel start bit |
| dma_dir_o | output | 2 | Per-channel direction bit |
| ch0_table_o | output | 32 | Channel 0 descriptor-table pointer |
| ch1_table_o | output | 32 | Channel 1 descriptor-table pointer |
| bar_low_o | output | 8 | Reset value of the window base-address low byte |

## Verification
The bench writes all 256 values to both status bytes, each time after a pulse has set the event flags. A design that mixes up which bits are write-one-to-clear, or that lets the write disturb the active flag or the zero bits, returns a wrong byte on readback. It also lands a clearing write and a set pulse in the same cycle, so a design that gives the write priority is caught. Wide accesses are swept at every offset, which catches a design that lets a 16-bit write through or pads wide reads wrongly. Byte and half-word writes to the pointer at each offset catch lane-shift errors and a failure to keep the low two bits at zero.

// File: rtl/dbm_regs.sv
module dbm_regs #(
  parameter int DW = 32,
  parameter logic [7:0] BAR_LOW = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    io_addr,
  input  logic [1:0]    io_size,
  input  logic          io_wr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic [1:0]    err_i,
  input  logic [1:0]    irq_i,
  output logic [1:0]    dma_start_o,
  output logic [1:0]    dma_dir_o,
  output logic [DW-1:0] ch0_table_o,
  output logic [DW-1:0] ch1_table_o,
  output logic [7:0]    bar_low_o
);
  localparam int NCH = 2;

  logic [NCH-1:0]          start_q, dir_q, act_q, err_q, irq_q;
  logic [NCH-1:0][1:0]     cap_q;
  logic [NCH-1:0][DW-1:0]  tbl_q;

  wire       ch_sel   = io_addr[3];
  wire       tbl_sel  = io_addr[2];
  wire [1:0] off      = io_addr[1:0];
  wire       byte_acc = (io_size == 2'd0);
  wire [4:0] sh       = {off, 3'b000};

  logic [DW-1:0] size_mask;
  always_comb begin
    case (io_size)
      2'd0:    size_mask = DW'(32'h0000_00FF);
      2'd1:    size_mask = DW'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
  end

  wire [DW-1:0] lane_mask = size_mask << sh;
  wire [DW-1:0] lane_data = io_wdata << sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      dir_q   <= '0;
      act_q   <= '0;
      err_q   <= '0;
      irq_q   <= '0;
      cap_q   <= '0;
      tbl_q   <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        logic hit, cmd_wr, st_wr;
        hit    = io_wr && (ch_sel == 1'(c));
        cmd_wr = hit && !tbl_sel && byte_acc && (off == 2'd0);
        st_wr  = hit && !tbl_sel && byte_acc && (off == 2'd2);
        if (cmd_wr) begin
          start_q[c] <= io_wdata[0];
          dir_q[c]   <= io_wdata[3];
          act_q[c]   <= io_wdata[0];
        end
        if (st_wr)
          cap_q[c] <= io_wdata[6:5];
        err_q[c] <= err_i[c] | (err_q[c] & ~(st_wr & io_wdata[1]));
        irq_q[c] <= irq_i[c] | (irq_q[c] & ~(st_wr & io_wdata[2]));
        if (hit && tbl_sel)
          tbl_q[c] <= ((tbl_q[c] & ~lane_mask) | (lane_data & lane_mask)) & ~DW'(3);
      end
    end
  end

  wire [7:0] cmd_byte  = {4'b0, dir_q[ch_sel], 2'b0, start_q[ch_sel]};
  wire [7:0] stat_byte = {1'b0, cap_q[ch_sel], 2'b0, irq_q[ch_sel], err_q[ch_sel], act_q[ch_sel]};

  always_comb begin
    if (tbl_sel)
      io_rdata = (tbl_q[ch_sel] >> sh) & size_mask;
    else if (!byte_acc)
      io_rdata = size_mask;
    else begin
      case (off)
        2'd0:    io_rdata = DW'(cmd_byte);
        2'd2:    io_rdata = DW'(stat_byte);
        default: io_rdata = DW'(8'hFF);
      endcase
    end
  end

  assign dma_start_o = start_q;
  assign dma_dir_o   = dir_q;
  assign ch0_table_o = tbl_q[0];
  assign ch1_table_o = tbl_q[1];
  assign bar_low_o   = BAR_LOW;
endmodule

// File: rtl/dbm_regs_chk.sv
module dbm_regs_chk #(
  parameter int DW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         io_addr,
  input logic [1:0]         io_size,
  input logic               io_wr,
  input logic [DW-1:0]      io_wdata,
  input logic [DW-1:0]      io_rdata,
  input logic [1:0]         err_i,
  input logic [1:0]         irq_i,
  input logic [1:0]         start_q,
  input logic [1:0]         act_q,
  input logic [1:0]         err_q,
  input logic [1:0]         irq_q,
  input logic [1:0][DW-1:0] tbl_q
);
  for (genvar c = 0; c < 2; c++) begin : g_ch
    wire st_wr = io_wr && (io_addr[3] == 1'(c)) && !io_addr[2] &&
                 (io_size == 2'd0) && (io_addr[1:0] == 2'd2);

    a_r8_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
      err_i[c] |=> err_q[c]);
    a_r8_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i[c] |=> irq_q[c]);
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && io_wdata[1] && !err_i[c]) |=> !err_q[c]);
    a_r6_act_kept: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr |=> $stable(act_q[c]));
    a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_q[c][1:0] == 2'b00);
  end

  a_r3_wide_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_addr[2] && io_size != 2'd0) |=> ($stable(start_q) && $stable(act_q)));
  a_r5_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_addr[2] && io_size == 2'd0 && io_addr[1:0] == 2'd2) |->
      (io_rdata[7] == 1'b0 && io_rdata[4:3] == 2'b00));
endmodule

bind dbm_regs dbm_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
  .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .err_i(err_i), .irq_i(irq_i), .start_q(start_q), .act_q(act_q),
  .err_q(err_q), .irq_q(irq_q), .tbl_q(tbl_q)
);

// File: tb/dbm_regs_tb.sv
module dbm_regs_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [1:0]  io_size = '0;
  logic        io_wr = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic [1:0]  err_i = '0, irq_i = '0;
  logic [1:0]  dma_start_o, dma_dir_o;
  logic [31:0] ch0_table_o, ch1_table_o;
  logic [7:0]  bar_low_o;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0]  m_cmd [2];
  logic [7:0]  m_st  [2];
  logic [31:0] m_tbl [2];

  always #(CLK_P/2) clk = ~clk;

  dbm_regs dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .err_i(err_i), .irq_i(irq_i), .dma_start_o(dma_start_o),
    .dma_dir_o(dma_dir_o), .ch0_table_o(ch0_table_o),
    .ch1_table_o(ch1_table_o), .bar_low_o(bar_low_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit wr, input logic [3:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic [1:0] e, input logic [1:0] q);
    @(negedge clk);
    io_wr = wr; io_addr = a; io_size = sz; io_wdata = d; err_i = e; irq_i = q;
    @(negedge clk);
    io_wr = 1'b0; err_i = '0; irq_i = '0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [1:0] sz,
                    input logic [31:0] exp);
    io_addr = a; io_size = sz;
    #1;
    chk(req, io_rdata, exp);
  endtask

  function automatic logic [31:0] tbl_next(input logic [31:0] old, input int off,
                                           input int nbytes, input logic [31:0] d);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++)
      if (b >= off && b < off + nbytes) r[b*8 +: 8] = d[(b-off)*8 +: 8];
    r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic [31:0] tbl_read(input logic [31:0] v, input int off, input int nbytes);
    logic [31:0] r = '0;
    for (int b = 0; b < nbytes; b++)
      if (off + b < 4) r[b*8 +: 8] = v[(off+b)*8 +: 8];
    return r;
  endfunction

  initial begin
    for (int c = 0; c < 2; c++) begin m_cmd[c] = 0; m_st[c] = 0; m_tbl[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    chk("R10 bar", {24'b0, bar_low_o}, 32'h01);
    for (int a = 0; a < 16; a++) begin
      logic [31:0] e;
      e = ((a % 4) == 1 || (a % 4) == 3) && (a % 8) < 4 ? 32'hFF : 32'h0;
      rd("R10 reset readback", 4'(a), 2'd0, e);
    end

    // R2, R6, R1: command sweep on both channels
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 256; v++) begin
        cyc(1, 4'(c*8), 2'd0, 32'(v), 2'b0, 2'b0);
        m_cmd[c] = {4'b0, v[3], 2'b0, v[0]};
        m_st[c][0] = v[0];
        rd("R2 cmd read", 4'(c*8), 2'd0, {24'b0, m_cmd[c]});
        chk("R2 start out", {31'b0, dma_start_o[c]}, {31'b0, v[0]});
        chk("R2 dir out", {31'b0, dma_dir_o[c]}, {31'b0, v[3]});
        rd("R6 active follows start", 4'(c*8+2), 2'd0, {24'b0, m_st[c]});
      end

    // R1: channel independence
    cyc(1, 4'd0, 2'd0, 32'h09, 2'b0, 2'b0);
    cyc(1, 4'd8, 2'd0, 32'h00, 2'b0, 2'b0);
    m_cmd[0] = 8'h09; m_st[0][0] = 1; m_cmd[1] = 8'h00; m_st[1][0] = 0;
    rd("R1 ch0 cmd", 4'd0, 2'd0, 32'h09);
    rd("R1 ch1 cmd", 4'd8, 2'd0, 32'h00);

    // R5, R6, R7: status sweep after pulses set events (R8)
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 256; v++) begin
        logic [1:0] pm;
        pm = 2'(1 << c);
        cyc(0, 4'd0, 2'd0, 32'h0, pm, pm);
        m_st[c][2:1] = 2'b11;
        rd("R8 pulses set", 4'(c*8+2), 2'd0, {24'b0, m_st[c]});
        cyc(1, 4'(c*8+2), 2'd0, 32'(v), 2'b0, 2'b0);
        m_st[c][6:5] = 2'(v >> 5);
        if (v[1]) m_st[c][1] = 0;
        if (v[2]) m_st[c][2] = 0;
        rd("R5 R7 status write", 4'(c*8+2), 2'd0, {24'b0, m_st[c]});
        chk("R6 start unaffected", {31'b0, dma_start_o[c]}, {31'b0, m_cmd[c][0]});
      end

    // R8: set wins over clear in same cycle
    cyc(1, 4'd2, 2'd0, 32'h06, 2'b01, 2'b01);
    m_st[0] = {1'b0, 2'b00, 2'b00, 1'b1, 1'b1, m_st[0][0]};
    rd("R8 set beats clear", 4'd2, 2'd0, {24'b0, m_st[0]});
    cyc(1, 4'd10, 2'd0, 32'h06, 2'b10, 2'b00);
    m_st[1] = {1'b0, 2'b00, 2'b00, 1'b0, 1'b1, m_st[1][0]};
    rd("R8 err only set", 4'd10, 2'd0, {24'b0, m_st[1]});

    // R3, R4: wide reads and odd byte offsets
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 4; o++) begin
        rd("R3 half read", 4'(c*8+o), 2'd1, 32'h0000FFFF);
        rd("R3 word read", 4'(c*8+o), 2'd2, 32'hFFFFFFFF);
        rd("R3 word read sz3", 4'(c*8+o), 2'd3, 32'hFFFFFFFF);
        if (o == 1 || o == 3) rd("R4 reserved byte", 4'(c*8+o), 2'd0, 32'hFF);
      end

    // R3: wide writes ignored
    for (int c = 0; c < 2; c++)
      for (int sz = 1; sz < 4; sz++)
        for (int o = 0; o < 4; o++) begin
          cyc(1, 4'(c*8+o), 2'(sz), 32'hFFFF_FFFF, 2'b0, 2'b0);
          rd("R3 wide write cmd", 4'(c*8), 2'd0, {24'b0, m_cmd[c]});
          rd("R3 wide write st", 4'(c*8+2), 2'd0, {24'b0, m_st[c]});
        end

    // R9: pointer lane writes
    for (int c = 0; c < 2; c++)
      for (int sz = 0; sz < 3; sz++)
        for (int o = 0; o < 4; o++) begin
          int nb;
          logic [31:0] d;
          nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
          if (o + nb > 4) continue;
          d = 32'hA5C3_96F7 ^ 32'(c * 32'h1111_1111 + sz * 16 + o);
          cyc(1, 4'(c*8+4+o), 2'(sz), d, 2'b0, 2'b0);
          m_tbl[c] = tbl_next(m_tbl[c], o, nb, d);
          chk("R9 table out", c ? ch1_table_o : ch0_table_o, m_tbl[c]);
          for (int ro = 0; ro < 4; ro++)
            rd("R9 table read byte", 4'(c*8+4+ro), 2'd0, tbl_read(m_tbl[c], ro, 1));
          rd("R9 table read word", 4'(c*8+4), 2'd2, m_tbl[c]);
        end
    cyc(1, 4'd4, 2'd2, 32'hFFFF_FFFF, 2'b0, 2'b0);
    rd("R9 low bits zero", 4'd4, 2'd2, 32'hFFFF_FFFC);
    rd("R1 ch1 pointer unchanged", 4'd12, 2'd2, m_tbl[1]);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule